// File: doc/BRIEF.md
# Key Slot Pool Allocator

This block hands out hardware key slot numbers for a crypto engine. A client raises an allocation request. In the next cycle it sees either a one-cycle grant pulse with a slot number, or a one-cycle failure pulse when no slot is free. Later it hands the slot back with a release request that carries the slot number.

Free slots are kept in a first-in, first-out ring. A slot that was released long ago is reused before one released recently. One slot index is kept out of the pool from reset because it holds a key placed at boot. It is never granted, and releasing it does nothing. A release of a slot that is already free is dropped and raises a sticky error flag. A release and an allocation in the same cycle are resolved release first, so an empty pool can serve the request with the slot that was just returned.

Top module: `key_slot_pool`

## Requirements
- R1: After reset, consecutive allocations return the slots in the order 0, 1, 2, 3, 5, 6, 7. The free count reads 7, and grant, failure and error are low.
- R2: An allocation request that finds a free slot gives a grant pulse exactly one cycle long, in the cycle after the request. The slot number is on `grant_slot` during that pulse. Failure stays low.
- R3: Slot 4 (the reserved index) is never presented with a grant.
- R4: An allocation request while the pool is empty gives a one-cycle failure pulse in the next cycle, with no grant, and the free count stays 0.
- R5: An accepted release appends the slot at the tail of the free ring, so later allocations return slots in the order they were released.
- R6: A release naming slot 4 is ignored. The free count and the allocation order do not change, and the error flag does not rise.
- R7: A release of a slot that is currently free is ignored and sets `double_free_err`. The flag stays high until reset.
- R8: When allocation and release requests arrive in the same cycle, the release is applied first. On an empty pool, the grant then carries the slot just released.
- R9: `free_count` gives the number of free slots (0 to 7), updated one cycle after the request that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request one slot this cycle |
| grant_valid | output | 1 | One-cycle pulse: a slot was handed out |
| grant_fail | output | 1 | One-cycle pulse: request found no free slot |
| grant_slot | output | 3 | Slot number handed out (valid with grant_valid) |
| rel_req | input | 1 | Return a slot this cycle |
| rel_slot | input | 3 | Slot number being returned |
| free_count | output | 3 | Number of free slots |
| double_free_err | output | 1 | Sticky flag: a free slot was released again |

## Verification
The hardest case to reach is the release-first merge on an empty pool. It needs the pool drained completely, and then, in the same cycle, an allocation and a release of an allocated slot. The stimulus drains every slot by allocation, then drives both requests together and checks that the grant carries the released slot. The double-free flag needs a slot that is already back in the pool to be released again. A directed sequence does this before a long random phase, and the flag must then stay high for the rest of the run. The random phase also keeps emptying and refilling the pool against a queue-based model, so the ring pointers wrap many times.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef enum logic [1:0] {
        REL_NONE   = 2'd0,
        REL_PUSH   = 2'd1,
        REL_IGNORE = 2'd2,
        REL_DOUBLE = 2'd3
    } rel_kind_e;

    // slot held at ring position idx after reset, skipping the reserved index
    function automatic int unsigned fill_slot(int unsigned idx, int unsigned reserved);
        return (idx < reserved) ? idx : idx + 1;
    endfunction

endpackage

// File: rtl/kp_rel_check.sv
module kp_rel_check
    import kp_pkg::*;
#(
    parameter int unsigned NUM_SLOTS     = 8,
    parameter int unsigned RESERVED_SLOT = 4,
    localparam int unsigned SLOT_W       = $clog2(NUM_SLOTS)
) (
    input  logic                 rel_req,
    input  logic [SLOT_W-1:0]    rel_slot,
    input  logic [NUM_SLOTS-1:0] free_map,
    output rel_kind_e            rel_kind
);
    logic in_range;

    generate
        if ((2 ** SLOT_W) == NUM_SLOTS) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_partial
            assign in_range = (32'(rel_slot) < NUM_SLOTS);
        end
    endgenerate

    always_comb begin
        if (!rel_req) begin
            rel_kind = REL_NONE;
        end else if (!in_range || rel_slot == SLOT_W'(RESERVED_SLOT)) begin
            rel_kind = REL_IGNORE;
        end else if (free_map[rel_slot]) begin
            rel_kind = REL_DOUBLE;
        end else begin
            rel_kind = REL_PUSH;
        end
    end
endmodule

// File: rtl/kp_ring.sv
module kp_ring
    import kp_pkg::*;
#(
    parameter int unsigned NUM_SLOTS     = 8,
    parameter int unsigned RESERVED_SLOT = 4,
    localparam int unsigned SLOT_W       = $clog2(NUM_SLOTS),
    localparam int unsigned DEPTH        = NUM_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_ptr,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_ptr,
    output logic [SLOT_W-1:0] rd_data
);
    logic [SLOT_W-1:0] mem_d [DEPTH];
    logic [SLOT_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_ptr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= (i < DEPTH - 1) ? SLOT_W'(fill_slot(i, RESERVED_SLOT)) : '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_ptr];
endmodule

// File: rtl/key_slot_pool.sv
module key_slot_pool
    import kp_pkg::*;
#(
    parameter int unsigned NUM_SLOTS     = 8,
    parameter int unsigned RESERVED_SLOT = 4,
    localparam int unsigned SLOT_W       = $clog2(NUM_SLOTS),
    localparam int unsigned CNT_W        = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic              grant_valid,
    output logic              grant_fail,
    output logic [SLOT_W-1:0] grant_slot,
    input  logic              rel_req,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic [CNT_W-1:0]  free_count,
    output logic              double_free_err
);
    localparam logic [NUM_SLOTS-1:0] MAP_INIT =
        {NUM_SLOTS{1'b1}} & ~(NUM_SLOTS'(1) << RESERVED_SLOT);
    localparam logic [SLOT_W-1:0] LAST_PTR = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0]    head;
        logic [SLOT_W-1:0]    tail;
        logic [CNT_W-1:0]     count;
        logic [NUM_SLOTS-1:0] map;
        logic                 grant;
        logic                 fail;
        logic [SLOT_W-1:0]    slot;
        logic                 err;
    } state_t;

    state_t    s_d, s_q;
    rel_kind_e rel_kind;
    logic [SLOT_W-1:0] ring_head_slot;
    logic              push;
    logic              pop;
    logic [CNT_W-1:0]  cnt_after_rel;
    logic [SLOT_W-1:0] pop_slot;

    kp_rel_check #(.NUM_SLOTS(NUM_SLOTS), .RESERVED_SLOT(RESERVED_SLOT)) i_rel_check (
        .rel_req  (rel_req),
        .rel_slot (rel_slot),
        .free_map (s_q.map),
        .rel_kind (rel_kind)
    );

    kp_ring #(.NUM_SLOTS(NUM_SLOTS), .RESERVED_SLOT(RESERVED_SLOT)) i_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_ptr  (s_q.tail),
        .wr_data (rel_slot),
        .rd_ptr  (s_q.head),
        .rd_data (ring_head_slot)
    );

    function automatic logic [SLOT_W-1:0] ptr_inc(logic [SLOT_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        push          = (rel_kind == REL_PUSH);
        cnt_after_rel = s_q.count + CNT_W'(push);
        pop           = alloc_req && (cnt_after_rel != '0);
        // empty ring: the only candidate is the slot being returned now
        pop_slot      = (s_q.count == '0) ? rel_slot : ring_head_slot;

        s_d       = s_q;
        s_d.grant = pop;
        s_d.fail  = alloc_req && !pop;
        s_d.count = cnt_after_rel - CNT_W'(pop);
        s_d.err   = s_q.err || (rel_kind == REL_DOUBLE);
        if (push) begin
            s_d.tail          = ptr_inc(s_q.tail);
            s_d.map[rel_slot] = 1'b1;
        end
        if (pop) begin
            s_d.head          = ptr_inc(s_q.head);
            s_d.map[pop_slot] = 1'b0;
            s_d.slot          = pop_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.head  <= '0;
            s_q.tail  <= LAST_PTR;
            s_q.count <= CNT_W'(NUM_SLOTS - 1);
            s_q.map   <= MAP_INIT;
            s_q.grant <= 1'b0;
            s_q.fail  <= 1'b0;
            s_q.slot  <= '0;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_valid     = s_q.grant;
    assign grant_fail      = s_q.fail;
    assign grant_slot      = s_q.slot;
    assign free_count      = s_q.count;
    assign double_free_err = s_q.err;
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
    parameter int unsigned NUM_SLOTS     = 8,
    parameter int unsigned RESERVED_SLOT = 4,
    localparam int unsigned SLOT_W       = $clog2(NUM_SLOTS),
    localparam int unsigned CNT_W        = $clog2(NUM_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              grant_valid,
    input logic              grant_fail,
    input logic [SLOT_W-1:0] grant_slot,
    input logic              rel_req,
    input logic [SLOT_W-1:0] rel_slot,
    input logic [CNT_W-1:0]  free_count,
    input logic              double_free_err
);
    localparam logic [SLOT_W-1:0] RES = SLOT_W'(RESERVED_SLOT);

    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && grant_fail));

    p_grant_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !rel_req && free_count != '0) |=>
        (grant_valid && free_count == CNT_W'($past(free_count) - 1'b1)));

    p_never_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_slot != RES));

    p_fail_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !rel_req && free_count == '0) |=> (grant_fail && !grant_valid));

    p_reserved_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && rel_slot == RES && !alloc_req) |=> $stable(free_count));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        double_free_err |=> double_free_err);

    p_merge_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && rel_req && rel_slot != RES && free_count == '0) |=>
        (grant_valid && grant_slot == $past(rel_slot)));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(free_count) <= NUM_SLOTS - 1);
endmodule

bind key_slot_pool kp_checker #(.NUM_SLOTS(NUM_SLOTS), .RESERVED_SLOT(RESERVED_SLOT)) i_kp_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .alloc_req       (alloc_req),
    .grant_valid     (grant_valid),
    .grant_fail      (grant_fail),
    .grant_slot      (grant_slot),
    .rel_req         (rel_req),
    .rel_slot        (rel_slot),
    .free_count      (free_count),
    .double_free_err (double_free_err)
);

// File: tb/test_key_slot_pool.sv
module test_key_slot_pool;
    localparam int CLK_PERIOD = 10;
    localparam int RES_SLOT   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 1'b0;
    logic       rel_req = 1'b0;
    logic [2:0] rel_slot = '0;
    logic       grant_valid, grant_fail, double_free_err;
    logic [2:0] grant_slot, free_count;

    int total = 0;
    int bad = 0;

    // reference model
    int fq[$];
    bit is_free[8];
    bit m_grant, m_fail, m_err;
    int m_slot;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_slot_pool i_key_slot_pool (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
        .grant_valid(grant_valid), .grant_fail(grant_fail), .grant_slot(grant_slot),
        .rel_req(rel_req), .rel_slot(rel_slot),
        .free_count(free_count), .double_free_err(double_free_err)
    );

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        fq.delete();
        for (int i = 0; i < 8; i++) begin
            is_free[i] = (i != RES_SLOT);
            if (i != RES_SLOT) fq.push_back(i);
        end
        m_grant = 0; m_fail = 0; m_err = 0; m_slot = 0;
    endtask

    task automatic model_step(bit a, bit r, int s);
        m_grant = 0; m_fail = 0;
        if (r && s != RES_SLOT) begin
            if (is_free[s]) m_err = 1;
            else begin fq.push_back(s); is_free[s] = 1; end
        end
        if (a) begin
            if (fq.size() > 0) begin
                m_slot = fq.pop_front(); is_free[m_slot] = 0; m_grant = 1;
            end else m_fail = 1;
        end
    endtask

    task automatic compare(string tag);
        check(tag, "grant_valid", grant_valid, m_grant);
        check(tag, "grant_fail", grant_fail, m_fail);
        if (m_grant) check(tag, "grant_slot", grant_slot, m_slot);
        check(tag, "free_count(R9)", free_count, fq.size());
        check(tag, "double_free_err", double_free_err, m_err);
        if (grant_valid) check("R3", "reserved never granted", int'(grant_slot == 3'(RES_SLOT)), 0);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(string tag, bit a, bit r, int s);
        alloc_req = a; rel_req = r; rel_slot = 3'(s);
        @(posedge clk);
        model_step(a, r, s);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // R1: reset order of the free ring, R2: single-cycle grant pulses
        for (int i = 0; i < 7; i++) step("R1", 1, 0, 0);
        step("R2", 0, 0, 0);
        // R4: empty pool
        step("R4", 1, 0, 0);
        step("R4", 1, 0, 0);
        step("R4", 0, 0, 0);
        // R5: FIFO return order
        step("R5", 0, 1, 6);
        step("R5", 0, 1, 2);
        step("R5", 0, 1, 0);
        // R6: reserved release between them changes nothing
        step("R6", 0, 1, RES_SLOT);
        step("R6", 0, 0, 0);
        step("R5", 1, 0, 0);
        step("R5", 1, 0, 0);
        step("R5", 1, 0, 0);
        // R8: merge on empty pool
        step("R8", 1, 1, 3);
        step("R8", 1, 1, 7);
        step("R8", 0, 0, 0);
        // R7: double free
        step("R7", 0, 1, 5);
        step("R7", 0, 1, 5);
        step("R7", 0, 0, 0);
        step("R7", 1, 0, 0);
        // R3: random mix, error must persist
        for (int i = 0; i < 400; i++) begin
            step("R3", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
                 int'($urandom_range(0, 7)));
        end
        alloc_req = 0; rel_req = 0;
        // reset again restores R1 order
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        compare("R1");
        for (int i = 0; i < 7; i++) step("R1", 1, 0, 0);
        step("R4", 1, 0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule